// File: doc/BRIEF.md
# Indirect-Address DMA Channel

This block is one DMA channel that copies bytes from memory to a single peripheral data register. Each transfer is started by a one-cycle request pulse from the peripheral. It takes the bus through a request/grant handshake, performs its accesses one at a time over a single-beat valid/ready master port, and then releases the bus. In indirect mode the source register holds the address of a 32-bit pointer. The channel reads that pointer, reads one byte at the address it holds, and writes that byte to the destination. In direct mode the byte is read from the source address itself.

Software sets up the channel through four word registers: source address, destination address, transfer count and control. The count drops by one on each transfer. When it reaches zero the channel stops and raises a sticky transfer-end flag. That flag also drives the interrupt output when interrupts are enabled.

Register select `reg_sel`: 0 = source, 1 = destination, 2 = count (low `CNT_W` bits), 3 = control. Control bits: [0] channel enable, [1] indirect mode, [2] interrupt enable, [3] transfer-end flag (writing 0 clears it, writing 1 leaves it unchanged).

Top module: `idma_channel`

## Requirements
- R1: After reset, `busy`, `bus_req`, `mem_valid`, `te_flag` and `irq` are 0, `src_addr` is 0 and `xfer_count` is 0.
- R2: A request pulse on `dreq` is accepted only while `glb_en` and the channel enable bit (control bit 0) are both 1 and the count is nonzero. A pulse that is not accepted is dropped and starts no later transfer.
- R3: In direct mode (control bit 1 = 0), one transfer is a byte read (`mem_size`=0, `mem_we`=0) at `src_addr`, followed by a byte write to the destination.
- R4: In indirect mode (control bit 1 = 1), one transfer is, in order: a 4-byte read (`mem_size`=1) at `src_addr`, a byte read at the 32-bit value returned, and a byte write to the destination.
- R5: The write carries `mem_rdata[7:0]` of the byte read and always uses the destination register as its address. The destination never changes.
- R6: After each transfer `src_addr` advances by 1 in direct mode and by 4 in indirect mode.
- R7: `xfer_count` drops by one per transfer. At zero, further requests start nothing.
- R8: `te_flag` becomes 1 on the transfer that brings the count to zero and stays 1 until control is written with bit 3 = 0. `irq` equals `te_flag` AND control bit 2.
- R9: `bus_req` rises after an accepted request and falls in the cycle after the write handshake. No access is issued while `bus_gnt` is 0.
- R10: Requests that arrive during a transfer are kept as one pending request, so any number of them produces exactly one extra transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global DMA enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| dreq | input | 1 | Peripheral transfer request pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Access valid |
| mem_ready | input | 1 | Access accepted / read data valid |
| mem_addr | output | 32 | Access address |
| mem_size | output | 1 | 1 = 4-byte access, 0 = byte access |
| mem_we | output | 1 | 1 = write |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 32 | Read data (byte reads use bits 7:0) |
| busy | output | 1 | Transfer in progress |
| src_addr | output | 32 | Current source address |
| xfer_count | output | CNT_W | Remaining transfer count |
| te_flag | output | 1 | Sticky transfer-end flag |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A wrong sequencer state shows up within one transfer. The access log would show a missing pointer read, a data read at the pointer address instead of through it, or a write before the grant. A stale or mis-stepped source or count register appears on `src_addr` and `xfer_count` in the cycle right after the write handshake. A lost or duplicated pending request changes the total number of writes seen before the channel goes idle. A flag set one transfer early or late shows on `te_flag` when the last write completes.

// File: rtl/idma_pkg.sv
package idma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_PTR  = 3'd2,
    ST_DAT  = 3'd3,
    ST_WR   = 3'd4
  } seq_state_t;

  // Source stride: one pointer word in indirect mode, one byte otherwise.
  function automatic logic [2:0] src_step(input logic indirect);
    return indirect ? 3'd4 : 3'd1;
  endfunction
endpackage

// File: rtl/idma_regs.sv
module idma_regs
  import idma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ch_en,
  output logic              indirect,
  output logic              irq_en,
  output logic              te_q
);
  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  function automatic logic last_one(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic unused_wbits;
  assign unused_wbits = &{reg_wdata[31:CNT_W], reg_wdata[31:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      ch_en    <= 1'b0;
      indirect <= 1'b0;
      irq_en   <= 1'b0;
      te_q     <= 1'b0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0: src_q <= reg_wdata[ADDR_W-1:0];
        2'd1: dst_q <= reg_wdata[ADDR_W-1:0];
        2'd2: cnt_q <= reg_wdata[CNT_W-1:0];
        default: begin
          ch_en    <= reg_wdata[0];
          indirect <= reg_wdata[1];
          irq_en   <= reg_wdata[2];
          if (!reg_wdata[3]) te_q <= 1'b0;
        end
      endcase
    end else if (xfer_done) begin
      src_q <= src_q + ADDR_W'(src_step(indirect));
      cnt_q <= count_after(cnt_q);
      if (last_one(cnt_q)) te_q <= 1'b1;
    end
  end

  // R7: a completed transfer lowers the count by exactly one
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !reg_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R8: the end flag only rises together with an empty count
  assert_te_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_q) |-> cnt_q == '0);

  // R6: the source moves by the stride of the mode in force
  assert_src_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !reg_wr) |=>
      (src_q - $past(src_q)) == ($past(indirect) ? ADDR_W'(4) : ADDR_W'(1)));
endmodule

// File: rtl/idma_seq.sv
module idma_seq
  import idma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dreq,
  input  logic              glb_en,
  input  logic              ch_en,
  input  logic              indirect,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_done
);
  seq_state_t        state_q, state_d;
  logic              pending_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        byte_q;
  logic              enabled, accept, start, hs;

  assign enabled = glb_en && ch_en && (cnt_q != '0);
  assign accept  = dreq && enabled;
  assign start   = (state_q == ST_IDLE) && pending_q && enabled;
  assign hs      = mem_valid && mem_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)   state_d = ST_ARB;
      ST_ARB:  if (bus_gnt) state_d = indirect ? ST_PTR : ST_DAT;
      ST_PTR:  if (hs)      state_d = ST_DAT;
      ST_DAT:  if (hs)      state_d = ST_WR;
      ST_WR:   if (hs)      state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= 1'b0;
      ptr_q     <= '0;
      byte_q    <= '0;
    end else begin
      state_q   <= state_d;
      pending_q <= (pending_q && !start) || accept;
      if (state_q == ST_PTR && hs) ptr_q  <= mem_rdata[ADDR_W-1:0];
      if (state_q == ST_DAT && hs) byte_q <= mem_rdata[7:0];
    end
  end

  always_comb begin
    mem_addr = dst_q;
    case (state_q)
      ST_PTR:  mem_addr = src_q;
      ST_DAT:  mem_addr = indirect ? ptr_q : src_q;
      default: mem_addr = dst_q;
    endcase
  end

  assign bus_req   = (state_q != ST_IDLE);
  assign mem_valid = (state_q == ST_PTR) || (state_q == ST_DAT) || (state_q == ST_WR);
  assign mem_size  = (state_q == ST_PTR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_wdata = byte_q;
  assign xfer_done = (state_q == ST_WR) && mem_ready;

  // R9: no access goes out without the bus grant
  assert_granted_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_gnt);

  // R9: the bus is only released right after a completed write
  assert_release_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(xfer_done));

  // R5: writes are byte-wide and aimed at the destination register
  assert_write_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr == dst_q && !mem_size));

  // R4: a pointer fetch is always followed by the data read
  assert_ptr_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_size && mem_ready) |=> (mem_valid && !mem_we && !mem_size));
endmodule

// File: rtl/idma_channel.sv
module idma_channel
  import idma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              dreq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] src_addr,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              te_flag,
  output logic              irq
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ch_en, indirect, irq_en, te_q, xfer_done;

  idma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .xfer_done(xfer_done), .src_q(src_q),
    .dst_q(dst_q), .cnt_q(cnt_q), .ch_en(ch_en), .indirect(indirect),
    .irq_en(irq_en), .te_q(te_q)
  );

  idma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .glb_en(glb_en), .ch_en(ch_en),
    .indirect(indirect), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_done(xfer_done)
  );

  assign busy       = bus_req;
  assign src_addr   = src_q;
  assign xfer_count = cnt_q;
  assign te_flag    = te_q;
  assign irq        = te_q && irq_en;

  // R8: interrupt never without the end flag
  assert_irq_needs_te_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> te_flag);
endmodule

// File: tb/idma_channel_test.sv
module idma_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0, reg_wr = 1'b0, dreq = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        bus_req, bus_gnt, mem_valid, mem_ready, mem_size, mem_we;
  logic [31:0] mem_addr, mem_rdata, src_addr;
  logic [7:0]  mem_wdata;
  logic [15:0] xfer_count;
  logic        busy, te_flag, irq;

  int tests = 0, fails = 0;
  int lat = 0, gdel = 0, gcnt = 0, wcnt = 0, log_n = 0, ungranted = 0, cycles = 0;
  logic [31:0] la [256];
  logic [7:0]  ld [256];
  logic        lw [256];
  logic        ls [256];

  always #2.5 clk = ~clk;

  idma_channel uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .src_addr(src_addr),
    .xfer_count(xfer_count), .te_flag(te_flag), .irq(irq)
  );

  function automatic logic [31:0] ptr_of(input logic [31:0] a);
    return 32'h2000_0000 | (a << 4);
  endfunction
  function automatic logic [7:0] byte_of(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_size ? ptr_of(mem_addr) : {24'h0, byte_of(mem_addr)};
  assign bus_gnt   = bus_req && (gcnt >= gdel);
  assign mem_ready = mem_valid && (wcnt >= lat);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    gcnt <= bus_req ? gcnt + 1 : 0;
    if (mem_valid && mem_ready) wcnt <= 0;
    else if (mem_valid) wcnt <= wcnt + 1;
    if (mem_valid && !bus_gnt) ungranted <= ungranted + 1;
    if (mem_valid && mem_ready) begin
      la[log_n[7:0]] <= mem_addr;
      ld[log_n[7:0]] <= mem_wdata;
      lw[log_n[7:0]] <= mem_we;
      ls[log_n[7:0]] <= mem_size;
      log_n <= log_n + 1;
    end
    if (cycles == 150000) begin
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic wait_idle(output logic started);
    started = 1'b0;
    for (int i = 0; i < 10 && !started; i++) begin
      if (busy) started = 1'b1; else @(negedge clk);
    end
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
  endtask

  // One transfer with full access-log checks (R3, R4, R5, R6, R7, R9)
  task automatic one_xfer(input logic indir, input logic [31:0] dst);
    int b, n;
    logic st;
    logic [31:0] s0, c0, daddr;
    s0 = src_addr; c0 = 32'(xfer_count); b = log_n;
    pulse();
    wait_idle(st);
    n = log_n - b;
    chk(st && !busy, "R9 bus_req raised then released", {30'd0, st, busy}, 32'd2);
    chk(!bus_req, "R9 bus released after write", {31'd0, bus_req}, 32'd0);
    chk(n == (indir ? 3 : 2), indir ? "R4 access count" : "R3 access count", n, indir ? 3 : 2);
    if (indir) begin
      chk(la[b[7:0]] == s0 && ls[b[7:0]] && !lw[b[7:0]], "R4 pointer read", la[b[7:0]], s0);
      daddr = ptr_of(s0);
      chk(la[8'(b+1)] == daddr && !ls[8'(b+1)] && !lw[8'(b+1)], "R4 data read via pointer", la[8'(b+1)], daddr);
    end else begin
      daddr = s0;
      chk(la[b[7:0]] == s0 && !ls[b[7:0]] && !lw[b[7:0]], "R3 direct byte read", la[b[7:0]], s0);
    end
    chk(la[8'(b+n-1)] == dst && lw[8'(b+n-1)] && !ls[8'(b+n-1)], "R5 write to destination", la[8'(b+n-1)], dst);
    chk(ld[8'(b+n-1)] == byte_of(daddr), "R5 write data", {24'd0, ld[8'(b+n-1)]}, {24'd0, byte_of(daddr)});
    chk(src_addr == s0 + (indir ? 4 : 1), "R6 source stride", src_addr, s0 + (indir ? 4 : 1));
    chk(32'(xfer_count) == c0 - 1, "R7 count decrement", 32'(xfer_count), c0 - 1);
  endtask

  initial begin
    logic st;
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req && !mem_valid && !te_flag && !irq && src_addr == 0 && xfer_count == 0,
        "R1 reset state", {27'd0, busy, bus_req, mem_valid, te_flag, irq}, 32'd0);

    // R2: disabled combinations ignore requests
    for (int g = 0; g < 2; g++) begin
      glb_en = g[0];
      wr(2'd2, 32'd4); wr(2'd0, 32'h100); wr(2'd1, 32'hFFFF_81B3);
      wr(2'd3, {31'd0, ~g[0]});
      pulse();
      repeat (8) @(negedge clk);
      chk(!busy && xfer_count == 4, "R2 request ignored while disabled", {15'd0, busy, xfer_count}, 32'd4);
      glb_en = 1'b1; wr(2'd3, 32'd1);
      repeat (8) @(negedge clk);
      chk(!busy && xfer_count == 4, "R2 dropped request not replayed", {15'd0, busy, xfer_count}, 32'd4);
    end

    // Sweep: mode x memory latency x grant delay
    glb_en = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 3; l++)
        for (int gd = 0; gd < 3; gd++) begin
          logic ie;
          ie = l[0] ^ gd[0];
          lat = l; gdel = gd;
          wr(2'd0, 32'h0040_0000 + 32'(l * 256 + gd * 16));
          wr(2'd1, 32'hFFFF_8100 + 32'(m));
          wr(2'd2, 32'd3);
          wr(2'd3, {28'd0, 1'b0, ie, m[0], 1'b1});
          for (int k = 0; k < 3; k++) begin
            one_xfer(m[0], 32'hFFFF_8100 + 32'(m));
            if (k < 2) chk(!te_flag, "R8 flag clear before last", {31'd0, te_flag}, 32'd0);
          end
          chk(te_flag, "R8 flag set at zero", {31'd0, te_flag}, 32'd1);
          chk(irq == ie, "R8 irq gated by enable", {31'd0, irq}, {31'd0, ie});
          b = log_n;
          pulse();
          repeat (8) @(negedge clk);
          chk(!busy && log_n == b && xfer_count == 0, "R7 stop at zero", log_n - b, 32'd0);
          wr(2'd3, {28'd0, 1'b1, ie, m[0], 1'b1});
          chk(te_flag, "R8 writing one keeps flag", {31'd0, te_flag}, 32'd1);
          wr(2'd3, {28'd0, 1'b0, ie, m[0], 1'b1});
          chk(!te_flag && !irq, "R8 flag cleared by write", {30'd0, te_flag, irq}, 32'd0);
        end

    // R10: several requests during a transfer become one extra transfer
    lat = 2; gdel = 2;
    wr(2'd0, 32'h500); wr(2'd1, 32'h900); wr(2'd2, 32'd5); wr(2'd3, 32'd3);
    b = log_n;
    pulse();
    for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
    pulse(); pulse(); pulse();
    repeat (80) @(negedge clk);
    chk(xfer_count == 3, "R10 pending collapses to one", 32'(xfer_count), 32'd3);
    chk(log_n - b == 6, "R10 access total", log_n - b, 32'd6);
    chk(src_addr == 32'h508, "R10 source after two", src_addr, 32'h508);

    chk(ungranted == 0, "R9 no access without grant", ungranted, 32'd0);
    st = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule